// File: doc/BRIEF.md
# Framed Serial Transmitter

This block is the transmit half of an asynchronous serial link. A parallel byte is written into a holding register with an active-low load strobe. It then moves into a shift register and leaves on a single serial line as a framed character. The framing is held in a small control register that is written with its own strobe. It sets the character length (5 to 8 data bits), whether a parity bit is sent and its sense, and whether one or two stop bits close the frame.

Every storage element, including the final serial output flop, is an edge-triggered register on the transmit clock. The load strobe may come from another clock domain, so it passes through a synchronizer before the holding register captures the data. Two flags tell the writer when a new byte may be written and when the line has gone fully quiet. A synchronous master reset puts the block in an idle state, and it accepts new work on the first clock edge after reset is released.

Top module: `uart_tx_framed`

## Requirements
- R1: The control register is written on a clock edge at which `cfg_load` is high. It keeps its value on every edge at which `cfg_load` is low. Reset sets it to 8 data bits, no parity and one stop bit.
- R2: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Holding-register bits above the selected length never reach the line and never affect parity.
- R3: A frame is a low start bit, then the data bits least-significant first, then the parity bit if enabled, then the high stop bit(s). Each bit lasts `BIT_TICKS` (16) clocks, and the line rests high when idle.
- R4: With `cfg_par_off` low, one parity bit is sent. `cfg_par_even` high gives an even number of ones over data plus parity, and low gives an odd number. With `cfg_par_off` high, no parity bit is sent.
- R5: `cfg_two_stop` low sends one stop bit and high sends two.
- R6: The holding register captures `hold_data` on the rising edge of `hold_load_n`. If the strobe is first sampled high at clock edge k, `buf_empty` is low after edge k+2 and not before.
- R7: When the buffer is full and the shifter is idle or finishing its last bit tick, the byte moves to the shifter and `buf_empty` goes high at that same edge. The start bit appears on `tx_out` one edge later, so frames sent back to back have no idle gap.
- R8: `tx_empty` is high exactly when the holding register is empty and no frame is being shifted out.
- R9: A clock edge with `rst` high makes `tx_out`, `buf_empty` and `tx_empty` high. A load strobe that is first sampled high on the second edge after release is taken normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high master reset |
| cfg_load | input | 1 | Control register write enable |
| cfg_len | input | 2 | Character length select (5 + value data bits) |
| cfg_par_off | input | 1 | High suppresses the parity bit |
| cfg_par_even | input | 1 | High selects even parity, low odd |
| cfg_two_stop | input | 1 | High selects two stop bits |
| hold_data | input | DATA_W | Byte to transmit |
| hold_load_n | input | 1 | Active-low load strobe; data taken on its rising edge |
| tx_out | output | 1 | Registered serial line |
| buf_empty | output | 1 | Holding register may be written |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
A wrong bit or tick count in the shifter stretches or shortens the frame. That shows up as a shift in the edge where `tx_empty` rises, exactly one bit time after the last stop bit starts. A wrong synchronizer depth moves the fall of `buf_empty` off edge k+2 within the same write. A framing or parity fault shows as a wrong bit in the captured frame within one character time. A lost handover between holding and shift registers either leaves `buf_empty` low past the end of the running frame or leaves a high gap before the next start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_off;
    logic       par_even;
    logic       two_stop;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{len_sel: 2'b11, par_off: 1'b1,
                                    par_even: 1'b0, two_stop: 1'b0};

endpackage

// File: rtl/uart_tx_sync.sv
module uart_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], strobe_n};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  tx_cfg_t cfg_in,
  output tx_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= CFG_RESET;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CW      = $clog2(FRAME_W + 1)
) (
  input  tx_cfg_t             cfg,
  input  logic [DATA_W-1:0]   data,
  output logic [FRAME_W-1:0]  frame,
  output logic [CW-1:0]       nbits
);
  localparam int MIN_BITS = DATA_W - 3;

  int   n_data;
  logic ones_odd;
  logic par_bit;

  always_comb begin
    n_data   = MIN_BITS + int'(cfg.len_sel);
    ones_odd = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n_data) ones_odd = ones_odd ^ data[i];
    end
    par_bit = cfg.par_even ? ones_odd : ~ones_odd;

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n_data) frame[i+1] = data[i];
    end
    if (!cfg.par_off) begin
      for (int i = 1; i < FRAME_W; i++) begin
        if (i == n_data + 1) frame[i] = par_bit;
      end
    end
    nbits = CW'(1 + n_data + (cfg.par_off ? 0 : 1) + (cfg.two_stop ? 2 : 1));
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int FRAME_W   = 12,
  parameter int CW        = 4,
  parameter int BIT_TICKS = 16,
  parameter int TW        = $clog2(BIT_TICKS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CW-1:0]      nbits,
  output logic               ready,
  output logic               busy,
  output logic               line
);
  logic [FRAME_W-1:0] sh_q;
  logic [CW-1:0]      left_q;
  logic [TW-1:0]      tick_q;
  logic               busy_q;
  logic               line_q;
  logic               tick_end;
  logic               last_tick;

  assign tick_end  = tick_q == TW'(BIT_TICKS - 1);
  assign last_tick = busy_q && tick_end && (left_q == CW'(1));
  assign ready     = !busy_q || last_tick;
  assign busy      = busy_q;
  assign line      = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      tick_q <= '0;
      busy_q <= 1'b0;
      line_q <= 1'b1;
    end else begin
      line_q <= busy_q ? sh_q[0] : 1'b1;
      if (load) begin
        sh_q   <= frame;
        left_q <= nbits;
        tick_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (tick_end) begin
          tick_q <= '0;
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - CW'(1);
          if (left_q == CW'(1)) busy_q <= 1'b0;
        end else begin
          tick_q <= tick_q + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx_framed.sv
module uart_tx_framed
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BIT_TICKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_off,
  input  logic              cfg_par_even,
  input  logic              cfg_two_stop,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_load_n,
  output logic              tx_out,
  output logic              buf_empty,
  output logic              tx_empty
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CW      = $clog2(FRAME_W + 1);

  tx_cfg_t             cfg_in;
  tx_cfg_t             cfg_q;
  logic                load_rise;
  logic [DATA_W-1:0]   hold_q;
  logic                full_q;
  logic                take;
  logic                sh_ready;
  logic                sh_busy;
  logic [FRAME_W-1:0]  frame;
  logic [CW-1:0]       nbits;

  assign cfg_in = '{len_sel: cfg_len, par_off: cfg_par_off,
                    par_even: cfg_par_even, two_stop: cfg_two_stop};

  uart_tx_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .load   (cfg_load),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  uart_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (hold_load_n),
    .rise     (load_rise)
  );

  assign take = full_q && sh_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (load_rise) begin
      hold_q <= hold_data;
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  uart_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CW(CW)) u_frame (
    .cfg   (cfg_q),
    .data  (hold_q),
    .frame (frame),
    .nbits (nbits)
  );

  uart_tx_shift #(.FRAME_W(FRAME_W), .CW(CW), .BIT_TICKS(BIT_TICKS)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (take),
    .frame (frame),
    .nbits (nbits),
    .ready (sh_ready),
    .busy  (sh_busy),
    .line  (tx_out)
  );

  assign buf_empty = ~full_q;
  assign tx_empty  = ~full_q & ~sh_busy;
endmodule

// File: rtl/uart_tx_framed_chk.sv
module uart_tx_framed_chk (
  input logic clk,
  input logic rst,
  input logic hold_load_n,
  input logic tx_out,
  input logic buf_empty,
  input logic tx_empty
);
  AST_BUF_DROP_DELAY: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_empty) |-> $past(hold_load_n, 3) && !$past(hold_load_n, 4)); // R6

  AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    ($rose(buf_empty) && !$past(rst)) |=> !tx_out); // R7

  AST_IDLE_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> buf_empty && tx_out); // R8

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> tx_out && buf_empty && tx_empty); // R9
endmodule

bind uart_tx_framed uart_tx_framed_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .hold_load_n (hold_load_n),
  .tx_out      (tx_out),
  .buf_empty   (buf_empty),
  .tx_empty    (tx_empty)
);

// File: tb/uart_tx_framed_tb.sv
module uart_tx_framed_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_len = 2'b00;
  logic       cfg_par_off = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic [7:0] hold_data = 8'h00;
  logic       hold_load_n = 1'b1;
  logic       tx_out, buf_empty, tx_empty;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_framed u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_len(cfg_len),
    .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .hold_data(hold_data),
    .hold_load_n(hold_load_n), .tx_out(tx_out), .buf_empty(buf_empty),
    .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic to_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic set_cfg(input int len, input int poff, input int peven, input int two);
    @(negedge clk);
    cfg_len = 2'(len); cfg_par_off = poff[0]; cfg_par_even = peven[0];
    cfg_two_stop = two[0]; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic exp_build(input logic [7:0] d, input int len, input int poff,
                           input int peven, input int two,
                           output logic [11:0] f, output int nb);
    int n, ones, pos;
    n = 5 + len; ones = 0;
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      ones += int'(d[i]);
    end
    pos = 1 + n;
    if (poff == 0) begin
      f[pos] = (peven != 0) ? ones[0] : ~ones[0];
      pos++;
    end
    nb = pos + ((two != 0) ? 2 : 1);
  endtask

  task automatic capture(input int first, input int nb, output logic [11:0] got);
    got = '1;
    for (int i = 0; i < nb; i++) begin
      to_cyc(first + 16 * i);
      got[i] = tx_out;
    end
  endtask

  // One frame on an idle block, with exact flag timing.
  task automatic run_frame(input logic [7:0] d, input int len, input int poff,
                           input int peven, input int two);
    logic [11:0] ef, got;
    int nb, k;
    exp_build(d, len, poff, peven, two, ef, nb);
    @(negedge clk); hold_data = d; hold_load_n = 1'b0;
    @(negedge clk); hold_load_n = 1'b1; k = cyc + 1;
    to_cyc(k + 1); chk(buf_empty == 1'b1, "R6", "buf_empty early", int'(buf_empty), 1);
    to_cyc(k + 2); chk(buf_empty == 1'b0, "R6", "buf_empty drop", int'(buf_empty), 0);
    to_cyc(k + 3); chk(buf_empty == 1'b1, "R7", "buf_empty after take", int'(buf_empty), 1);
    chk(tx_out == 1'b1, "R3", "line idle before start", int'(tx_out), 1);
    to_cyc(k + 4); chk(tx_out == 1'b0, "R7", "start bit", int'(tx_out), 0);
    capture(k + 12, nb, got);
    // R2 R3 R4 R5: whole frame compared bit by bit
    chk(got == ef, "R3 R2 R4 R5", "frame", int'(got), int'(ef));
    to_cyc(k + 2 + 16 * nb); chk(tx_empty == 1'b0, "R8", "tx_empty early", int'(tx_empty), 0);
    to_cyc(k + 3 + 16 * nb); chk(tx_empty == 1'b1, "R8", "tx_empty end", int'(tx_empty), 1);
    chk(tx_out == 1'b1, "R3", "line high after frame", int'(tx_out), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] ef, got;
    int nb, k, c0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(tx_out == 1'b1, "R9", "reset tx_out", int'(tx_out), 1);
    chk(buf_empty == 1'b1, "R9", "reset buf_empty", int'(buf_empty), 1);
    chk(tx_empty == 1'b1, "R9", "reset tx_empty", int'(tx_empty), 1);
    rst = 1'b0;

    // R1 default framing: 8 data bits, no parity, one stop
    run_frame(8'hB4, 3, 1, 0, 0);

    // Sweep of every framing with several bytes (R2 R3 R4 R5 R6 R7 R8)
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int two = 0; two < 2; two++) begin
          set_cfg(len, (pm == 0) ? 1 : 0, (pm == 1) ? 1 : 0, two);
          run_frame(8'hE1, len, (pm == 0) ? 1 : 0, (pm == 1) ? 1 : 0, two);
          run_frame(8'h5A, len, (pm == 0) ? 1 : 0, (pm == 1) ? 1 : 0, two);
          run_frame(8'((len * 71 + pm * 29 + two * 113) ^ 8'h9C), len,
                    (pm == 0) ? 1 : 0, (pm == 1) ? 1 : 0, two);
        end

    // R1: framing inputs change without cfg_load: no effect
    set_cfg(3, 1, 0, 0);
    @(negedge clk);
    cfg_len = 2'b00; cfg_par_off = 1'b0; cfg_par_even = 1'b1; cfg_two_stop = 1'b1;
    run_frame(8'hC3, 3, 1, 0, 0);

    // R7 back-to-back frames, 8N1
    set_cfg(3, 1, 0, 0);
    @(negedge clk); hold_data = 8'h96; hold_load_n = 1'b0;
    @(negedge clk); hold_load_n = 1'b1; k = cyc + 1;
    to_cyc(k + 4); hold_data = 8'h3D; hold_load_n = 1'b0;
    @(negedge clk); hold_load_n = 1'b1;
    to_cyc(k + 9); chk(buf_empty == 1'b0, "R6", "second byte held", int'(buf_empty), 0);
    exp_build(8'h96, 3, 1, 0, 0, ef, nb);
    capture(k + 12, nb, got);
    chk(got == ef, "R7", "first frame", int'(got), int'(ef));
    to_cyc(k + 162); chk(buf_empty == 1'b0, "R7", "buffer still full", int'(buf_empty), 0);
    to_cyc(k + 163); chk(buf_empty == 1'b1, "R7", "handover at last tick", int'(buf_empty), 1);
    chk(tx_out == 1'b1, "R7", "last stop of first", int'(tx_out), 1);
    to_cyc(k + 164); chk(tx_out == 1'b0, "R7", "no gap start", int'(tx_out), 0);
    exp_build(8'h3D, 3, 1, 0, 0, ef, nb);
    capture(k + 172, nb, got);
    chk(got == ef, "R7", "second frame", int'(got), int'(ef));
    to_cyc(k + 323); chk(tx_empty == 1'b1, "R8", "empty after pair", int'(tx_empty), 1);

    // R9 reset mid-frame, then immediate operation with default framing
    set_cfg(0, 0, 1, 1);
    @(negedge clk); hold_data = 8'hFF; hold_load_n = 1'b0;
    @(negedge clk); hold_load_n = 1'b1;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(tx_out == 1'b1, "R9", "mid reset tx_out", int'(tx_out), 1);
    chk(buf_empty == 1'b1, "R9", "mid reset buf_empty", int'(buf_empty), 1);
    chk(tx_empty == 1'b1, "R9", "mid reset tx_empty", int'(tx_empty), 1);
    rst = 1'b0; hold_data = 8'h21; hold_load_n = 1'b0; c0 = cyc;
    @(negedge clk); hold_load_n = 1'b1; k = c0 + 2;
    to_cyc(k + 2); chk(buf_empty == 1'b0, "R9", "load right after reset", int'(buf_empty), 0);
    to_cyc(k + 4); chk(tx_out == 1'b0, "R9", "start right after reset", int'(tx_out), 0);
    // R1 reset default gives a 10-bit frame
    to_cyc(k + 162); chk(tx_empty == 1'b0, "R1", "default length early", int'(tx_empty), 0);
    to_cyc(k + 163); chk(tx_empty == 1'b1, "R1", "default length end", int'(tx_empty), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule